// File: doc/BRIEF.md
# USB Transfer Descriptor Status Writeback

This block forms the updated control/status word of a full-speed host-controller transfer descriptor once a bus transaction has ended. The packet engine gives it a one-cycle completion pulse. With that pulse come the transaction's outcome flags (handshake kind, receive CRC error, response timeout, bit-stuff violation, babble, buffer overrun or underrun), the transferred byte count, the token kind and the descriptor's current status word. One clock later the block presents the rewritten word on a single-cycle write strobe, ready to be stored back to memory.

The status bits 22:16 are rebuilt from scratch for each transaction, and several of them are coupled. Babble implies stalled. Any stall drops the active bit. A NAK or STALL reply to a SETUP also marks the CRC/timeout bit. A 2-bit retry counter is held in bits 28:27. Each transfer fault decrements it, and the descriptor stalls once the counter reaches zero. A counter that is already zero means retries are unlimited. When babble is seen, the block also raises a frame-abort request alongside the write strobe. The scheduler then skips the rest of the current frame and carries on at the next frame-list entry.

The stream runs in one direction only and has no back-pressure. Every completion is accepted in the cycle it arrives, and every writeback must be taken in the cycle its strobe is high. Completions may arrive back to back.

Top module: `usbtd_status_wb`

## Requirements
- R1: `wb_valid_o` is high in exactly the cycle after each cycle with `done_i` high and low otherwise; `frame_abort_o` is never high without `wb_valid_o`.
- R2: Bits 10:0 of the written word equal the byte count minus one modulo 2048 (zero bytes gives 0x7FF); bits 15:11 are written as zero.
- R3: Babble (`babble_i`) sets bit 20 and bit 22, clears the active bit 23, and raises `frame_abort_o` with the strobe.
- R4: A STALL handshake (`hs_i` = 2'b11) sets bit 22 and clears bit 23 while leaving the counter in bits 28:27 unchanged.
- R5: Whenever a written word has bit 22 set, its bit 23 is zero.
- R6: For a SETUP token (`tok_i` = 2'b10), a NAK (`hs_i` = 2'b10) or STALL reply also sets bit 18.
- R7: A receive CRC error or a response timeout sets bit 18; a timeout additionally sets the turnaround-timeout bit 16; a bit-stuff violation sets bit 17.
- R8: Overrun or underrun sets bit 21; after an underrun the descriptor keeps bit 23 set unless the counter was exhausted by it.
- R9: A fault (CRC error, timeout, bit-stuff, overrun or underrun) decrements a nonzero counter in bits 28:27 by one; reaching zero this way sets bit 22.
- R10: With the counter at zero, faults set their status bits but neither change the counter nor stall; bit 23 stays set.
- R11: An ACK (`hs_i` = 2'b01) with no fault and no babble clears bit 23 and writes bits 22:16 as zero.
- R12: A NAK to an OUT (`tok_i` = 2'b00) or IN (`tok_i` = 2'b01) token keeps bit 23 set, keeps the counter, and sets only bit 19 among bits 22:16.
- R13: Bits 31:29 and 26:24 of the written word are copied from `status_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Transaction completion pulse; outcome inputs valid with it |
| tok_i | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| hs_i | input | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| crc_err_i | input | 1 | Receive CRC error |
| timeout_i | input | 1 | No response within the turnaround window |
| stuff_err_i | input | 1 | More than six consecutive ones received |
| babble_i | input | 1 | Bus activity past the allowed end |
| overrun_i | input | 1 | Receive buffer could not keep up |
| underrun_i | input | 1 | Transmit data could not be supplied in time |
| bytes_i | input | 11 | Bytes actually transferred |
| status_i | input | 32 | Current descriptor control/status word |
| wb_valid_o | output | 1 | One-cycle writeback strobe |
| wb_word_o | output | 32 | Updated control/status word |
| frame_abort_o | output | 1 | Request to stop the current frame |

## Verification
On every cycle, the assertions check the strobe timing and the pairing of abort with the strobe. They also check that a stall always drops active, that babble always carries a stall, the reserved zeros, the length encoding, the pass-through fields, and that the counter never rises. A zero counter must never produce a stall from faults alone. The bench scenarios are the only place the exact combinations are compared. These cover a clean ACK against NAKs on plain and SETUP tokens, underrun with and without counter exhaustion, and unlimited retries at a zero counter, as well as back-to-back completions.

// File: rtl/usbtd_pkg.sv
package usbtd_pkg;
  localparam int unsigned TD_WORD_W   = 32;
  localparam int unsigned TD_LEN_W    = 11;
  localparam int unsigned TD_CNT_W    = 2;

  localparam int unsigned POS_CNT_LO  = 27;
  localparam int unsigned POS_CNT_HI  = POS_CNT_LO + TD_CNT_W - 1;
  localparam int unsigned POS_ACTIVE  = 23;
  localparam int unsigned POS_FLAG_HI = 22;
  localparam int unsigned POS_FLAG_LO = 16;
  localparam int unsigned FLAG_W      = POS_FLAG_HI - POS_FLAG_LO + 1;
  localparam int unsigned POS_RSV_HI  = POS_FLAG_LO - 1;
  localparam int unsigned POS_RSV_LO  = TD_LEN_W;
  localparam int unsigned RSV_W       = POS_RSV_HI - POS_RSV_LO + 1;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_RSVD  = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  // Field order matches status bits 22 down to 16.
  typedef struct packed {
    logic stall;
    logic buf_err;
    logic babble;
    logic nak;
    logic crc_to;
    logic stuff;
    logic turn_to;
  } flags_t;
endpackage

// File: rtl/usbtd_fault_decode.sv
module usbtd_fault_decode
  import usbtd_pkg::*;
(
  input  tok_e   tok,
  input  hs_e    hs,
  input  logic   crc_err,
  input  logic   timeout,
  input  logic   stuff_err,
  input  logic   babble,
  input  logic   overrun,
  input  logic   underrun,
  output flags_t raw_flags,
  output logic   fault_evt,
  output logic   clean_ack
);
  logic setup_reject;
  logic hs_stall;

  assign hs_stall     = (hs == HS_STALL);
  assign setup_reject = (tok == TOK_SETUP) && ((hs == HS_NAK) || hs_stall);
  assign fault_evt    = crc_err | timeout | stuff_err | overrun | underrun;
  assign clean_ack    = (hs == HS_ACK) && !fault_evt && !babble;

  always_comb begin
    raw_flags         = '0;
    raw_flags.stall   = babble | hs_stall;
    raw_flags.buf_err = overrun | underrun;
    raw_flags.babble  = babble;
    raw_flags.nak     = (hs == HS_NAK);
    raw_flags.crc_to  = crc_err | timeout | setup_reject;
    raw_flags.stuff   = stuff_err;
    raw_flags.turn_to = timeout;
  end
endmodule

// File: rtl/usbtd_errcnt.sv
module usbtd_errcnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             fault_evt,
  output logic [CNT_W-1:0] cnt_out,
  output logic             exhausted
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed;

  assign armed = (cnt_in != '0);

  always_comb begin
    cnt_out   = cnt_in;
    exhausted = 1'b0;
    if (fault_evt && armed) begin
      cnt_out   = cnt_in - ONE;
      exhausted = (cnt_in == ONE);
    end
  end
endmodule

// File: rtl/usbtd_len_enc.sv
module usbtd_len_enc #(
  parameter int unsigned LEN_W = 11
) (
  input  logic [LEN_W-1:0] bytes,
  output logic [LEN_W-1:0] len_field
);
  assign len_field = bytes - LEN_W'(1);
endmodule

// File: rtl/usbtd_status_wb.sv
module usbtd_status_wb
  import usbtd_pkg::*;
#(
  parameter int unsigned WORD_W = TD_WORD_W,
  parameter int unsigned LEN_W  = TD_LEN_W,
  parameter int unsigned CNT_W  = TD_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [1:0]        tok_i,
  input  logic [1:0]        hs_i,
  input  logic              crc_err_i,
  input  logic              timeout_i,
  input  logic              stuff_err_i,
  input  logic              babble_i,
  input  logic              overrun_i,
  input  logic              underrun_i,
  input  logic [LEN_W-1:0]  bytes_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              wb_valid_o,
  output logic [WORD_W-1:0] wb_word_o,
  output logic              frame_abort_o
);
  localparam int unsigned CNT_LO = POS_CNT_LO;
  localparam int unsigned CNT_HI = CNT_LO + CNT_W - 1;

  flags_t             raw_f;
  flags_t             fin_f;
  logic               fault_evt;
  logic               clean_ack;
  logic [CNT_W-1:0]   cnt_nxt;
  logic               exhausted;
  logic [LEN_W-1:0]   len_field;
  logic               active_nxt;
  logic [WORD_W-1:0]  word_nxt;

  usbtd_fault_decode u_decode (
    .tok       (tok_e'(tok_i)),
    .hs        (hs_e'(hs_i)),
    .crc_err   (crc_err_i),
    .timeout   (timeout_i),
    .stuff_err (stuff_err_i),
    .babble    (babble_i),
    .overrun   (overrun_i),
    .underrun  (underrun_i),
    .raw_flags (raw_f),
    .fault_evt (fault_evt),
    .clean_ack (clean_ack)
  );

  usbtd_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .cnt_in    (status_i[CNT_HI:CNT_LO]),
    .fault_evt (fault_evt),
    .cnt_out   (cnt_nxt),
    .exhausted (exhausted)
  );

  usbtd_len_enc #(.LEN_W(LEN_W)) u_len (
    .bytes     (bytes_i),
    .len_field (len_field)
  );

  always_comb begin
    fin_f       = raw_f;
    fin_f.stall = raw_f.stall | exhausted;
  end

  // A stall always wins; a clean ACK retires the descriptor; anything else retries.
  assign active_nxt = !(fin_f.stall || clean_ack);

  always_comb begin
    word_nxt                          = status_i;
    word_nxt[CNT_HI:CNT_LO]           = cnt_nxt;
    word_nxt[POS_ACTIVE]              = active_nxt;
    word_nxt[POS_FLAG_HI:POS_FLAG_LO] = fin_f;
    word_nxt[POS_RSV_HI:POS_RSV_LO]   = '0;
    word_nxt[LEN_W-1:0]               = len_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_o    <= 1'b0;
      frame_abort_o <= 1'b0;
      wb_word_o     <= '0;
    end else begin
      wb_valid_o    <= done_i;
      frame_abort_o <= done_i & babble_i;
      if (done_i) begin
        wb_word_o <= word_nxt;
      end
    end
  end
endmodule

// File: rtl/usbtd_status_wb_chk.sv
module usbtd_status_wb_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_i,
  input logic [1:0]        tok_i,
  input logic [1:0]        hs_i,
  input logic              crc_err_i,
  input logic              timeout_i,
  input logic              stuff_err_i,
  input logic              babble_i,
  input logic              overrun_i,
  input logic              underrun_i,
  input logic [LEN_W-1:0]  bytes_i,
  input logic [WORD_W-1:0] status_i,
  input logic              wb_valid_o,
  input logic [WORD_W-1:0] wb_word_o,
  input logic              frame_abort_o
);
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> wb_valid_o);
  p_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !wb_valid_o);
  p_abort_paired_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort_o |-> wb_valid_o);
  p_len_minus_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> wb_word_o[LEN_W-1:0] == LEN_W'($past(bytes_i) - LEN_W'(1)));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> wb_word_o[15:LEN_W] == '0);
  p_babble_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && wb_word_o[20]) |-> (wb_word_o[22] && frame_abort_o));
  p_stall_drops_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && wb_word_o[22]) |-> !wb_word_o[23]);
  p_cnt_never_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> wb_word_o[27 +: CNT_W] <= $past(status_i[27 +: CNT_W]));
  p_zero_cnt_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && status_i[27 +: CNT_W] == '0 && hs_i != 2'b11 && !babble_i)
      |=> !wb_word_o[22]);
  p_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (wb_word_o[31:29] == $past(status_i[31:29]) &&
                wb_word_o[26:24] == $past(status_i[26:24])));
endmodule

bind usbtd_status_wb usbtd_status_wb_chk #(
  .WORD_W(WORD_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/usbtd_status_wb_tb_top.sv
module usbtd_status_wb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0;
  logic [1:0]  tok_i = '0;
  logic [1:0]  hs_i = '0;
  logic        crc_err_i = 1'b0, timeout_i = 1'b0, stuff_err_i = 1'b0;
  logic        babble_i = 1'b0, overrun_i = 1'b0, underrun_i = 1'b0;
  logic [10:0] bytes_i = '0;
  logic [31:0] status_i = '0;
  logic        wb_valid_o;
  logic [31:0] wb_word_o;
  logic        frame_abort_o;

  int checks = 0;
  int failures = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  usbtd_status_wb dut_i (.*);

  // Expected word from the requirements: {abort, word}
  function automatic logic [32:0] model(input logic [1:0] tok, input logic [1:0] hs,
      input logic crc, input logic to, input logic stf, input logic bab,
      input logic ovr, input logic udr, input logic [10:0] nb, input logic [31:0] st);
    logic fault, exh, clean, act;
    logic [1:0] c;
    logic [6:0] f;
    fault = crc | to | stf | ovr | udr;
    c = st[28:27];
    exh = 1'b0;
    if (fault && c != 2'd0) begin
      c = c - 2'd1;                    // R9
      exh = (c == 2'd0);
    end
    f[6] = bab | (hs == 2'b11) | exh;  // R3 R4 R9
    f[5] = ovr | udr;                  // R8
    f[4] = bab;
    f[3] = (hs == 2'b10);              // R12
    f[2] = crc | to | ((tok == 2'b10) && hs[1]); // R6 R7
    f[1] = stf;
    f[0] = to;
    clean = (hs == 2'b01) && !fault && !bab; // R11
    act = !(f[6] || clean);            // R5
    return {bab, st[31:29], c, st[26:24], act, f, 5'b0, nb - 11'd1};
  endfunction

  task automatic send(input string tag, input logic [1:0] tok, input logic [1:0] hs,
      input logic crc, input logic to, input logic stf, input logic bab,
      input logic ovr, input logic udr, input logic [10:0] nb, input logic [31:0] st);
    done_i = 1'b1; tok_i = tok; hs_i = hs; crc_err_i = crc; timeout_i = to;
    stuff_err_i = stf; babble_i = bab; overrun_i = ovr; underrun_i = udr;
    bytes_i = nb; status_i = st;
    exp_q.push_back(model(tok, hs, crc, to, stf, bab, ovr, udr, nb, st));
    tag_q.push_back(tag);
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_valid_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected strobe actual=1 expected=0");
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({frame_abort_o, wb_word_o} !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, {frame_abort_o, wb_word_o}, e);
          end
        end
      end else if (frame_abort_o) begin
        checks++;
        failures++;
        $display("FAIL R1 abort without strobe actual=1 expected=0");
      end
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    checks++;
    if (wb_valid_o !== 1'b0 || frame_abort_o !== 1'b0 || wb_word_o !== 32'h0) begin
      failures++;
      $display("FAIL R1 reset actual=%b%b%h expected=000000000", wb_valid_o, frame_abort_o, wb_word_o);
    end
    rst_n = 1'b1;
    idle(2);
    //   tag          tok   hs     crc  to   stf  bab  ovr  udr  bytes   status
    send("R11 ack",   2'b00, 2'b01, 0,0,0,0,0,0, 11'd8,  32'h1880_0000);
    send("R2 zero",   2'b01, 2'b01, 0,0,0,0,0,0, 11'd0,  32'h1880_0000);
    idle(2);
    send("R12 nak",   2'b01, 2'b10, 0,0,0,0,0,0, 11'd0,  32'h1080_0000);
    send("R6 nak",    2'b10, 2'b10, 0,0,0,0,0,0, 11'd0,  32'h1880_0000);
    send("R6 stall",  2'b10, 2'b11, 0,0,0,0,0,0, 11'd0,  32'h1880_0000);
    send("R4 stall",  2'b01, 2'b11, 0,0,0,0,0,0, 11'd3,  32'h1080_0000);
    send("R3 babble", 2'b01, 2'b00, 0,0,0,1,0,0, 11'd64, 32'h1880_0000);
    idle(1);
    send("R7 R9 crc", 2'b01, 2'b00, 1,0,0,0,0,0, 11'd5,  32'h1880_0000);
    send("R5 R9 to",  2'b00, 2'b00, 0,1,0,0,0,0, 11'd0,  32'h0880_0000);
    send("R7 stuff",  2'b01, 2'b00, 0,0,1,0,0,0, 11'd2,  32'h1080_0000);
    send("R8 udr",    2'b00, 2'b01, 0,0,0,0,0,1, 11'd9,  32'h1080_0000);
    send("R8 udr ex", 2'b00, 2'b01, 0,0,0,0,0,1, 11'd9,  32'h0880_0000);
    send("R10 ovr",   2'b01, 2'b00, 0,0,0,0,1,0, 11'd4,  32'h0080_0000);
    send("R10 crc",   2'b01, 2'b00, 1,0,0,0,0,0, 11'd4,  32'h0080_0000);
    send("R13 pass",  2'b00, 2'b01, 0,0,0,0,0,0, 11'd1023, 32'hE780_0000);
    send("R2 max",    2'b01, 2'b01, 0,0,0,0,0,0, 11'd2047, 32'hE780_0000);
    idle(4);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (wb_valid_o !== 1'b0) begin
        failures++;
        $display("FAIL R1 idle strobe actual=%b expected=0", wb_valid_o);
      end
      @(negedge clk);
    end
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 missing writebacks actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule